// File: doc/BRIEF.md
# Cache Line-Range Maintenance Sequencer

This block sits beside a cache and carries out maintenance over a span of physical memory without software touching each line. Software programs a first byte address and an exclusive limit address, then writes a control word. That word carries a go bit and a two-bit operation code. The sequencer aligns the first address down to a 64-byte line. It then hands one line address at a time to the cache over a valid/ready port, moving to the next line each time a request is accepted.

The go bit also serves as the busy indicator. It reads back as 1 while the walk is running and drops by itself once the final line has been accepted, so a driver can poll the control word for completion. Three operation codes are defined:
- flush-and-drop: write back and invalidate.
- drop-only: invalidate without write-back.
- publish: write back while keeping the line valid and shared.

The fourth code is reserved and finishes without issuing any request. Addresses are 40 bits wide inside 64-bit registers.

Top module: `line_sweep_top`

## Requirements
- R1: After reset the busy bit is 0, `reqValid` is 0, and the first-address, limit and control registers read as 0.
- R2: The first-address register sits at byte offset 0x00 and the limit register at offset 0x08. Each keeps write-data bits [39:0] and reads back with bits [63:40] as zero.
- R3: The control register at offset 0x10 reads back the busy bit in bit 0 and the latched operation code in bits [2:1], with all other bits zero.
- R4: A walk issues requests at `first & ~63`, then at each following 64-byte line in ascending order. It issues exactly as many requests as there are lines whose address is below the limit.
- R5: While `reqValid` is 1 and `reqReady` is 0, the line address and operation code stay unchanged and `reqValid` stays 1.
- R6: Busy drops at the clock edge that accepts the last request, so it reads 0 in the cycle after that acceptance.
- R7: If the limit is less than or equal to the first address when go is written, no request is issued and busy is 1 for exactly one cycle.
- R8: Operation code 3 issues no request and keeps busy at 1 for exactly one cycle.
- R9: While busy is 1, writes to the first-address, limit and control registers have no effect.
- R10: A control write with bit 0 clear starts nothing and leaves the control readback unchanged.
- R11: Every request carries the operation code written in control bits [2:1]. Code 0 is flush-and-drop, 1 is drop-only and 2 is publish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 5 | Register byte offset (0x00, 0x08 or 0x10) |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 64 | Register write data |
| regRdData | output | 64 | Combinational read data for `regAddr` |
| reqValid | output | 1 | A maintenance request is presented |
| reqReady | input | 1 | The cache accepts the presented request |
| reqLineAddr | output | 40 | Line-aligned address of the request |
| reqMode | output | 2 | Operation code of the request |

## Verification
Two things can land on the same clock edge: acceptance of the final line and the self-clearing of busy. The bench provokes this across a sweep of first-address offsets and span lengths. It throttles `reqReady` in a rotating stall pattern, so the last acceptance follows both stalled and unstalled cycles. The check that busy reads 0 in the very next cycle judges this case, together with an exact count of the requests issued. A second collision comes from register writes landing during a walk. For that case the bench reads back the registers afterwards and confirms that the request stream carried on undisturbed.

// File: rtl/line_sweep_pkg.sv
package line_sweep_pkg;

  typedef enum logic [1:0] {
    OP_FLUSH_DROP = 2'd0,
    OP_DROP_ONLY  = 2'd1,
    OP_PUBLISH    = 2'd2,
    OP_RESERVED   = 2'd3
  } sweepOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadFirst;
    logic loadLimit;
    logic launch;
    logic advance;
  } sweepCmd_t;

  localparam logic [4:0] OFS_FIRST = 5'h00;
  localparam logic [4:0] OFS_LIMIT = 5'h08;
  localparam logic [4:0] OFS_CTRL  = 5'h10;

endpackage

// File: rtl/line_sweep_dp.sv
module line_sweep_dp
  import line_sweep_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  sweepCmd_t         cmd,
  input  logic [63:0]       wrData,
  output logic [ADDR_W-1:0] firstQ,
  output logic [ADDR_W-1:0] limitQ,
  output logic [ADDR_W-1:0] curLine,
  output sweepOp_e          opQ,
  output logic              rangeDone,
  output logic              lastLine,
  output logic              skipOp
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic              emptyQ;
  logic [ADDR_W:0]   nextLine;
  logic [ADDR_W-1:0] alignedFirst;

  generate
    if (OFF_W == 0) begin : g_noAlign
      assign alignedFirst = firstQ;
    end else begin : g_align
      assign alignedFirst = {firstQ[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end
  endgenerate

  assign nextLine  = {1'b0, curLine} + (ADDR_W+1)'(LINE_BYTES);
  assign rangeDone = emptyQ || (curLine >= limitQ);
  assign lastLine  = nextLine >= {1'b0, limitQ};
  assign skipOp    = (opQ == OP_RESERVED);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstQ  <= '0;
      limitQ  <= '0;
      curLine <= '0;
      opQ     <= OP_FLUSH_DROP;
      emptyQ  <= 1'b0;
    end else begin
      if (cmd.loadFirst) firstQ <= wrData[ADDR_W-1:0];
      if (cmd.loadLimit) limitQ <= wrData[ADDR_W-1:0];
      if (cmd.launch) begin
        curLine <= alignedFirst;
        opQ     <= sweepOp_e'(wrData[2:1]);
        emptyQ  <= (limitQ <= firstQ);
      end else if (cmd.advance) begin
        curLine <= nextLine[ADDR_W-1:0];
      end
    end
  end
endmodule

// File: rtl/line_sweep_ctl.sv
module line_sweep_ctl
  import line_sweep_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      regWrEn,
  input  logic [4:0] regAddr,
  input  logic      goBit,
  input  logic      rangeDone,
  input  logic      lastLine,
  input  logic      skipOp,
  input  logic      reqReady,
  output sweepCmd_t cmd,
  output logic      busy,
  output logic      reqValid
);
  typedef enum logic {ST_IDLE, ST_WALK} ctlState_e;
  ctlState_e state, stateNext;

  logic wrOk;

  assign busy     = (state == ST_WALK);
  assign wrOk     = regWrEn && !busy;
  assign reqValid = busy && !skipOp && !rangeDone;

  always_comb begin
    cmd.loadFirst = wrOk && (regAddr == OFS_FIRST);
    cmd.loadLimit = wrOk && (regAddr == OFS_LIMIT);
    cmd.launch    = wrOk && (regAddr == OFS_CTRL) && goBit;
    cmd.advance   = reqValid && reqReady;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (cmd.launch) stateNext = ST_WALK;
      ST_WALK: begin
        if (skipOp || rangeDone)         stateNext = ST_IDLE;
        else if (cmd.advance && lastLine) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/line_sweep_top.sv
module line_sweep_top
  import line_sweep_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        regAddr,
  input  logic              regWrEn,
  input  logic [63:0]       regWrData,
  output logic [63:0]       regRdData,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [ADDR_W-1:0] reqLineAddr,
  output logic [1:0]        reqMode
);
  sweepCmd_t         cmd;
  logic              busyNow, rangeDone, lastLine, skipOp;
  logic [ADDR_W-1:0] firstQ, limitQ, curLine;
  sweepOp_e          opQ;

  line_sweep_ctl uCtl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .goBit(regWrData[0]), .rangeDone(rangeDone), .lastLine(lastLine),
    .skipOp(skipOp), .reqReady(reqReady), .cmd(cmd), .busy(busyNow),
    .reqValid(reqValid)
  );

  line_sweep_dp #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(regWrData),
    .firstQ(firstQ), .limitQ(limitQ), .curLine(curLine), .opQ(opQ),
    .rangeDone(rangeDone), .lastLine(lastLine), .skipOp(skipOp)
  );

  assign reqLineAddr = curLine;
  assign reqMode     = opQ;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      OFS_FIRST: regRdData[ADDR_W-1:0] = firstQ;
      OFS_LIMIT: regRdData[ADDR_W-1:0] = limitQ;
      OFS_CTRL:  regRdData[2:0]        = {opQ, busyNow};
      default:   regRdData             = '0;
    endcase
  end
endmodule

// File: rtl/line_sweep_chk.sv
module line_sweep_chk #(
  parameter int ADDR_W     = 40,
  parameter int LINE_BYTES = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqLineAddr,
  input logic [1:0]        reqMode,
  input logic [4:0]        regAddr,
  input logic [63:0]       regRdData
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  // R1: no request outside a walk
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !reqValid);

  // R2: address registers read back zero above the address width
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 5'h00 || regAddr == 5'h08) |-> regRdData[63:ADDR_W] == '0);

  // R3: control readback has nothing above the operation code
  p_ctrl_clean_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 5'h10) |-> regRdData[63:3] == '0);

  // R4: requests are line aligned
  p_aligned_r4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> reqLineAddr[OFF_W-1:0] == '0);

  // R4: consecutive requests step by one line
  p_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=>
      (!reqValid || reqLineAddr == $past(reqLineAddr) + ADDR_W'(LINE_BYTES)));

  // R5: stalled request holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=>
      (reqValid && $stable(reqLineAddr) && $stable(reqMode)));

  // R8: reserved code never reaches the port
  p_no_reserved_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> reqMode != 2'd3);
endmodule

bind line_sweep_top line_sweep_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) uChk (
  .clk(clk), .rstN(rstN), .busy(busyNow), .reqValid(reqValid),
  .reqReady(reqReady), .reqLineAddr(reqLineAddr), .reqMode(reqMode),
  .regAddr(regAddr), .regRdData(regRdData)
);

// File: tb/tb_line_sweep_top.sv
module tb_line_sweep_top;
  localparam int AW = 40;

  logic          clk = 1'b0;
  logic          rstN;
  logic [4:0]    regAddr;
  logic          regWrEn;
  logic [63:0]   regWrData;
  logic [63:0]   regRdData;
  logic          reqValid;
  logic          reqReady;
  logic [AW-1:0] reqLineAddr;
  logic [1:0]    reqMode;

  int  total = 0;
  int  bad = 0;
  int  cyc = 0;

  always #2 clk = ~clk;

  line_sweep_top dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .reqValid(reqValid),
    .reqReady(reqReady), .reqLineAddr(reqLineAddr), .reqMode(reqMode)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [63:0] d);
    @(negedge clk);
    regAddr = a; regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 5'h10;
  endtask

  task automatic rd(input logic [4:0] a, output logic [63:0] d);
    regAddr = a;
    #1;
    d = regRdData;
    regAddr = 5'h10;
  endtask

  task automatic runOp(input logic [63:0] s, input logic [63:0] e, input logic [1:0] m, input bit meddle);
    logic [AW-1:0] sm, em;
    logic [AW:0]   a, expAddr, prevAddr;
    logic [63:0]   d;
    int  expN, got;
    bit  acceptPend, lastPend, stallPend, rdy, busyObs, done;
    sm = s[AW-1:0]; em = e[AW-1:0];
    expN = 0;
    a = {1'b0, sm[AW-1:6], 6'b0};
    if (m != 2'd3 && em > sm) begin
      while (a < {1'b0, em}) begin expN++; a = a + 64; end
    end
    expAddr = {1'b0, sm[AW-1:6], 6'b0};
    prevAddr = '0;
    wr(5'h00, s);
    wr(5'h08, e);
    @(negedge clk);
    regAddr = 5'h10; regWrEn = 1'b1; regWrData = {61'b0, m, 1'b1};
    got = 0; acceptPend = 0; lastPend = 0; stallPend = 0; done = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (acceptPend) begin got++; expAddr = expAddr + 64; end
      d = regRdData;
      busyObs = d[0];
      if (k == 0) begin
        chk(busyObs == 1'b1, "R7 busy set after go", {63'b0, busyObs}, 64'd1);
        chk(d[2:1] == m, "R3 ctrl mode readback", {62'b0, d[2:1]}, {62'b0, m});
      end
      if (lastPend && regAddr == 5'h10)
        chk(busyObs == 1'b0, "R6 busy drop after last accept", {63'b0, busyObs}, 64'd0);
      if (reqValid) begin
        chk(got < expN, "R4 request count bound", 64'(got), 64'(expN));
        chk({1'b0, reqLineAddr} == expAddr, "R4 line address", 64'(reqLineAddr), 64'(expAddr));
        chk(reqMode == m, "R11 request mode", {62'b0, reqMode}, {62'b0, m});
        if (stallPend)
          chk({1'b0, reqLineAddr} == prevAddr, "R5 stalled address held", 64'(reqLineAddr), 64'(prevAddr));
      end else if (stallPend) begin
        chk(1'b0, "R5 valid dropped under stall", 64'd0, 64'd1);
      end
      if (regAddr == 5'h10 && !busyObs && k > 0) begin
        chk(got == expN, "R4 total requests", 64'(got), 64'(expN));
        if (expN == 0)
          chk(k == 1, (m == 2'd3) ? "R8 reserved one cycle" : "R7 empty one cycle", 64'(k), 64'd1);
        done = 1;
        break;
      end
      regWrEn = 1'b0; regAddr = 5'h10;
      if (meddle && k >= 1 && k <= 3) begin
        regWrEn = 1'b1;
        regAddr = 5'((k - 1) * 8);
        regWrData = 64'h0000_00AA_5555_0007;
      end
      rdy = (((k + int'(s[3:0])) % 3) != 1);
      reqReady = rdy;
      acceptPend = reqValid && rdy;
      stallPend = reqValid && !rdy;
      prevAddr = {1'b0, reqLineAddr};
      lastPend = acceptPend && (got + 1 == expN);
    end
    regWrEn = 1'b0; reqReady = 1'b0; regAddr = 5'h10;
    if (!done) chk(1'b0, "R4 walk finished", 64'd0, 64'd1);
    rd(5'h00, d);
    chk(d == {24'b0, sm}, meddle ? "R9 first kept" : "R2 first readback", d, {24'b0, sm});
    rd(5'h08, d);
    chk(d == {24'b0, em}, meddle ? "R9 limit kept" : "R2 limit readback", d, {24'b0, em});
    if (meddle) begin
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        chk(!reqValid && !regRdData[0], "R9 no restart from busy write", {63'b0, reqValid}, 64'd0);
      end
    end
  endtask

  initial begin
    logic [63:0] d;
    rstN = 1'b0; regAddr = 5'h10; regWrEn = 1'b0; regWrData = '0; reqReady = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!reqValid, "R1 valid after reset", {63'b0, reqValid}, 64'd0);
    rd(5'h10, d); chk(d == 64'd0, "R1 ctrl after reset", d, 64'd0);
    rd(5'h00, d); chk(d == 64'd0, "R1 first after reset", d, 64'd0);
    rd(5'h08, d); chk(d == 64'd0, "R1 limit after reset", d, 64'd0);

    // sweep of offsets and lengths, upper garbage bits in the writes (R2)
    begin
      int idx = 0;
      for (int so = 0; so < 144; so += 9) begin
        for (int ln = 0; ln < 280; ln += 20) begin
          logic [63:0] base, st, en;
          base = 64'hC300_00F0_0000_2000;
          st = base + 64'(so);
          en = base + 64'(so + ln);
          runOp(st, en, 2'(idx % 3), 1'b0);
          idx++;
        end
      end
    end

    // R7: limit below first, limit equal to first
    runOp(64'h1000, 64'h0FF0, 2'd0, 1'b0);
    runOp(64'h1050, 64'h1048, 2'd1, 1'b0);
    runOp(64'h2040, 64'h2040, 2'd2, 1'b0);
    // R8: reserved code over a non-empty span
    runOp(64'h4000, 64'h4100, 2'd3, 1'b0);
    // span ending at the top of the address space
    runOp(64'h0000_00FF_FFFF_FF00, 64'h0000_00FF_FFFF_FFFF, 2'd2, 1'b0);
    // R9: writes during a long walk
    runOp(64'h8010, 64'h8290, 2'd1, 1'b1);

    // R10: control write without go
    runOp(64'h9000, 64'h9080, 2'd2, 1'b0);
    wr(5'h10, 64'h0000_0000_0000_0002);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk(!reqValid, "R10 no walk without go", {63'b0, reqValid}, 64'd0);
    end
    rd(5'h10, d);
    chk(d == 64'd4, "R10 ctrl unchanged", d, 64'd4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule